// File: doc/BRIEF.md
# Tearing-Effect Sync Line Detector

This block watches one tearing-effect pin driven by a display panel. The panel signals horizontal and vertical sync on that same pin, so the block tells them apart by how long each pulse lasts. Pulse widths are measured in ticks. A tick comes from a divide-by-1-to-8 clock enable, which is the same rate the display bus engine uses. Each sync type has its own polarity inversion.

Software writes one 32-bit configuration word. That word holds both width thresholds, a target line number, a match mode and the two inversion bits. After each vertical sync the block counts horizontal syncs. Depending on the mode, it emits an active-low, single-cycle match pulse either on every vertical sync or when the line count reaches the target. The downstream logic uses the falling edge of that pulse to release a pending frame transfer.

A separate enable input, taken from the bus engine's control, gates the whole detector.

Top module: `tesync_det`

## Requirements
- R1: The configuration register resets to 0. A write with `cfg_wr` high stores `cfg_wdata`, and `cfg_rdata` returns it on the next cycle with bits [31:30] forced to 0. The field layout is:
  - [2:0]: horizontal width code.
  - [14:3]: vertical width code.
  - [25:15]: target line.
  - [27:26]: mode.
  - [28]: vertical invert.
  - [29]: horizontal invert.
- R2: `div_sel` = N gives one tick every N+1 clocks. Pulse widths are counted in ticks. `te_pin` passes through a two-flop synchroniser before it is sampled.
- R3: A run of the vertical active level (synchronised pin XOR bit 28) that lasts at least (bits[14:3]+1)*8 ticks is a vertical sync. The sync is recognised at the tick that sees the run end. A run one tick shorter is not a vertical sync.
- R4: A run of the horizontal active level (pin XOR bit 29) is a horizontal sync when its width is at least bits[2:0]+1 ticks and below the vertical threshold. Shorter runs are ignored.
- R5: With bits 28 and 29 set, low-going pulses on `te_pin` are classified as sync pulses and high-going ones are not.
- R6: In mode 3, every vertical sync produces one match pulse, and horizontal syncs produce none.
- R7: In mode 2, the line count is as follows:
  - A vertical sync clears the count to 0.
  - Each horizontal sync adds 1 to the count.
  - A single match pulse fires when the count reaches the target line. A target of 0 matches at the vertical sync itself.
  - No match occurs before the first vertical sync after enabling.
- R8: Mode 0, mode 1 or `te_en` low disables the detector. No match is produced and all width and line state is cleared.
- R9: `match_n` is high out of reset and when idle. A match drives it low for exactly one clock, two clocks after the tick that ends the triggering pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| te_en | input | 1 | Tearing-effect enable from the bus engine |
| div_sel | input | 3 | Tick divider select, divide by value+1 |
| te_pin | input | 1 | Asynchronous tearing-effect pin |
| match_n | output | 1 | Active-low single-cycle match pulse |

## Verification
The bench targets the exact threshold edges:
- A vertical pulse of exactly the threshold width versus one tick short. A design comparing with the wrong inequality would miss the sync or report a horizontal one.
- Horizontal pulses one tick below the vertical threshold and one tick below the horizontal minimum.
- A target line of zero.
- Horizontal pulses arriving before any vertical sync. A matcher that was not armed by vertical sync would fire early.
- Extra horizontal pulses after the target. A matcher that did not disarm would fire twice.

Inverted polarity and a divide-by-4 tick are also exercised. At divide-by-4, a 40-clock pulse must count as horizontal, so a design measuring in clocks instead of ticks would report it as vertical.

// File: rtl/tesync_pkg.sv
package tesync_pkg;
  localparam int CFG_W  = 32;
  localparam int HWID_W = 3;
  localparam int VWID_W = 12;
  localparam int LINE_W = 11;
  localparam int MODE_W = 2;
  localparam int VSCALE = 3;  // vertical code counts units of 2**VSCALE ticks

  localparam logic [CFG_W-1:0] CFG_MASK = 32'h3FFF_FFFF;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 2'd0,
    MODE_RSVD  = 2'd1,
    MODE_LINE  = 2'd2,
    MODE_VSYNC = 2'd3
  } mode_e;

  typedef struct packed {
    logic [1:0]        spare;
    logic              h_inv;
    logic              v_inv;
    mode_e             mode;
    logic [LINE_W-1:0] line;
    logic [VWID_W-1:0] vwid;
    logic [HWID_W-1:0] hwid;
  } cfg_t;
endpackage

// File: rtl/tesync_tick_gen.sv
module tesync_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  // a ge compare recovers at once if div_sel shrinks mid-count
  assign tick = (cnt_q >= div_sel);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tesync_width_meas.sv
module tesync_width_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             level,
  output logic             run_end,
  output logic [CNT_W-1:0] run_len
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q   <= '0;
      run_end <= 1'b0;
      run_len <= '0;
    end else begin
      run_end <= 1'b0;
      if (tick) begin
        if (level) begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        end else begin
          run_end <= (cnt_q != '0);
          run_len <= cnt_q;
          cnt_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tesync_line_match.sv
module tesync_line_match
  import tesync_pkg::*;
#(
  parameter int LW = LINE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  mode_e         mode,
  input  logic [LW-1:0] target,
  input  logic          v_evt,
  input  logic          h_evt,
  output logic          match_n
);
  logic [LW-1:0] line_q;
  logic [LW-1:0] line_nx;
  logic          armed_q;

  assign line_nx = line_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      armed_q <= 1'b0;
      match_n <= 1'b1;
    end else begin
      match_n <= 1'b1;
      if (!en) begin
        line_q  <= '0;
        armed_q <= 1'b0;
      end else if (v_evt) begin
        line_q <= '0;
        if (mode == MODE_VSYNC || target == '0) begin
          match_n <= 1'b0;
          armed_q <= 1'b0;
        end else begin
          armed_q <= 1'b1;
        end
      end else if (h_evt) begin
        line_q <= line_nx;
        if (mode == MODE_LINE && armed_q && line_nx == target) begin
          match_n <= 1'b0;
          armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tesync_det.sv
module tesync_det
  import tesync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             te_en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             te_pin,
  output logic             match_n
);
  localparam int NCLS = 2;  // 0: vertical, 1: horizontal

  cfg_t                   cfg_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic                   tick;
  logic                   en;
  logic [NCLS-1:0]        inv;
  logic [NCLS-1:0]        run_end;
  logic [CNT_W-1:0]       run_len [NCLS];
  logic [VWID_W:0]        vunits;
  logic [CNT_W-1:0]       vthr;
  logic [CNT_W-1:0]       hthr;
  logic                   v_evt;
  logic                   h_evt;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata & CFG_MASK);
  end
  assign cfg_rdata = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], te_pin};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  assign en = te_en && (cfg_q.mode == MODE_LINE || cfg_q.mode == MODE_VSYNC);

  tesync_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick)
  );

  assign inv = {cfg_q.h_inv, cfg_q.v_inv};

  for (genvar g = 0; g < NCLS; g++) begin : g_meas
    tesync_width_meas #(.CNT_W(CNT_W)) u_meas (
      .clk(clk), .rst(rst), .clr(!en), .tick(tick),
      .level(pin_s ^ inv[g]),
      .run_end(run_end[g]), .run_len(run_len[g])
    );
  end

  assign vunits = {1'b0, cfg_q.vwid} + 1'b1;
  assign vthr   = CNT_W'({vunits, {VSCALE{1'b0}}});
  assign hthr   = CNT_W'({1'b0, cfg_q.hwid} + 1'b1);

  assign v_evt = run_end[0] && (run_len[0] >= vthr);
  assign h_evt = run_end[1] && (run_len[1] >= hthr) && (run_len[1] < vthr);

  tesync_line_match #(.LW(LINE_W)) u_match (
    .clk(clk), .rst(rst), .en(en), .mode(cfg_q.mode), .target(cfg_q.line),
    .v_evt(v_evt), .h_evt(h_evt), .match_n(match_n)
  );
endmodule

// File: rtl/tesync_det_chk.sv
module tesync_det_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        match_n,
  input logic        v_evt,
  input logic        h_evt,
  input logic        tick,
  input logic        en
);
  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_wr) && $past(!rst)) |-> (cfg_rdata == ($past(cfg_wdata) & 32'h3FFF_FFFF))); // R1

  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (v_evt || h_evt) |-> $past(tick)); // R2

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(v_evt && h_evt)); // R4

  AST_VSYNC_MODE_FIRES: assert property (@(posedge clk) disable iff (rst)
    (en && v_evt && cfg_rdata[27:26] == 2'd3) |=> !match_n); // R6

  AST_MATCH_FROM_EVT: assert property (@(posedge clk) disable iff (rst)
    $fell(match_n) |-> $past(v_evt || h_evt)); // R7

  AST_OFF_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    !en |=> match_n); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !match_n |=> match_n); // R9
endmodule

bind tesync_det tesync_det_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .match_n(match_n), .v_evt(v_evt), .h_evt(h_evt),
  .tick(tick), .en(en)
);

// File: tb/sim_tesync_det.sv
`timescale 1ns/1ps
module sim_tesync_det;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        te_en = 1'b1;
  logic [2:0]  div_sel = 3'd0;
  logic        te_pin = 1'b0;
  logic        match_n;

  int checks = 0;
  int fails  = 0;
  int seen   = 0;
  bit done   = 1'b0;
  bit model_ok = 1'b0;

  always #10 clk = ~clk;

  tesync_det u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .te_en(te_en), .div_sel(div_sel),
    .te_pin(te_pin), .match_n(match_n)
  );

  // behavioural reference, state advanced once per rising edge
  int          m_cnt, m_vcnt, m_hcnt, m_vlen, m_hlen, m_line;
  bit          m_s1, m_s2, m_vend, m_hend, m_armed, m_match_n;
  logic [31:0] m_cfg;

  always @(posedge clk) begin
    int  vthr, hw, mode, tgt;
    bit  en, vev, hev, fire, tick, lv, lh;
    if (rst) begin
      m_cnt = 0; m_vcnt = 0; m_hcnt = 0; m_vlen = 0; m_hlen = 0; m_line = 0;
      m_s1 = 0; m_s2 = 0; m_vend = 0; m_hend = 0; m_armed = 0;
      m_match_n = 1; m_cfg = '0;
    end else begin
      mode = int'(m_cfg[27:26]);
      tgt  = int'(m_cfg[25:15]);
      vthr = (int'(m_cfg[14:3]) + 1) * 8;
      hw   = int'(m_cfg[2:0]) + 1;
      en   = te_en && (mode >= 2);
      vev  = m_vend && (m_vlen >= vthr);
      hev  = m_hend && (m_hlen >= hw) && (m_hlen < vthr);
      fire = 0;
      if (!en) begin
        m_line = 0; m_armed = 0;
      end else if (vev) begin
        m_line = 0; m_armed = 1;
        if (mode == 3 || tgt == 0) begin fire = 1; m_armed = 0; end
      end else if (hev) begin
        m_line = (m_line + 1) % 2048;
        if (mode == 2 && m_armed && m_line == tgt) begin fire = 1; m_armed = 0; end
      end
      m_match_n = !fire;
      tick = (m_cnt >= int'(div_sel));
      if (!en) begin
        m_vcnt = 0; m_hcnt = 0; m_vend = 0; m_hend = 0; m_vlen = 0; m_hlen = 0;
      end else begin
        m_vend = 0; m_hend = 0;
        if (tick) begin
          lv = m_s2 ^ m_cfg[28];
          lh = m_s2 ^ m_cfg[29];
          if (lv) begin if (m_vcnt < 65535) m_vcnt++; end
          else begin m_vend = (m_vcnt != 0); m_vlen = m_vcnt; m_vcnt = 0; end
          if (lh) begin if (m_hcnt < 65535) m_hcnt++; end
          else begin m_hend = (m_hcnt != 0); m_hlen = m_hcnt; m_hcnt = 0; end
        end
      end
      m_cnt = tick ? 0 : m_cnt + 1;
      m_s2 = m_s1;
      m_s1 = te_pin;
      if (cfg_wr) m_cfg = cfg_wdata & 32'h3FFF_FFFF;
    end
    model_ok = 1'b1;
  end

  // every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (model_ok && !done) begin
      checks++;
      if (match_n !== m_match_n) begin
        fails++;
        $display("FAIL R9 match_n cycle compare: actual %b expected %b", match_n, m_match_n);
      end
      checks++;
      if (cfg_rdata !== m_cfg) begin
        fails++;
        $display("FAIL R1 cfg_rdata compare: actual %h expected %h", cfg_rdata, m_cfg);
      end
      if (match_n === 1'b0) seen++;
    end
  end

  function automatic logic [31:0] mk(int hwf, int vwf, int tgt, int mode, bit vinv, bit hinv);
    logic [31:0] v;
    v = '0;
    v[2:0] = 3'(hwf); v[14:3] = 12'(vwf); v[25:15] = 11'(tgt);
    v[27:26] = 2'(mode); v[28] = vinv; v[29] = hinv;
    return v;
  endfunction

  task automatic wcfg(logic [31:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // go through a disabled setting first so each scenario starts clean
  task automatic setup(int tgt, int mode, bit vinv, bit hinv, bit idle);
    wcfg(mk(2, 1, tgt, 0, vinv, hinv));
    te_pin = idle;
    repeat (8) @(negedge clk);
    wcfg(mk(2, 1, tgt, mode, vinv, hinv));
    seen = 0;
  endtask

  task automatic pulse(bit act, bit idle, int n);
    @(negedge clk); te_pin = act;
    repeat (n) @(negedge clk);
    te_pin = idle;
    repeat (60) @(negedge clk);
  endtask

  task automatic expect_seen(int exp, string tag);
    checks++;
    if (seen != exp) begin
      fails++;
      $display("FAIL %s match count: actual %0d expected %0d", tag, seen, exp);
    end
    seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (match_n !== 1'b1 || cfg_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R1 R9 reset state: actual %b/%h expected 1/00000000", match_n, cfg_rdata);
    end
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R1: spare bits read back as zero
    wcfg(32'hFFFF_FFFF);
    checks++;
    if (cfg_rdata !== 32'h3FFF_FFFF) begin
      fails++;
      $display("FAIL R1 spare bits: actual %h expected 3fffffff", cfg_rdata);
    end

    // R6 / R3: vsync-only mode and the vertical threshold edge (16 ticks)
    setup(0, 3, 0, 0, 0);
    pulse(1, 0, 20); expect_seen(1, "R6 vsync");
    pulse(1, 0, 6);  expect_seen(0, "R6 hsync ignored");
    pulse(1, 0, 16); expect_seen(1, "R3 at threshold");
    pulse(1, 0, 15); expect_seen(0, "R3 below threshold");

    // R4 / R7: line mode, target 1
    setup(1, 2, 0, 0, 0);
    pulse(1, 0, 5);  expect_seen(0, "R7 before vsync");
    pulse(1, 0, 20); expect_seen(0, "R7 vsync target 1");
    pulse(1, 0, 15); expect_seen(1, "R4 width 15 is hsync");
    pulse(1, 0, 5);  expect_seen(0, "R7 once per frame");
    pulse(1, 0, 20);
    pulse(1, 0, 2);  expect_seen(0, "R4 short pulse ignored");
    pulse(1, 0, 3);  expect_seen(1, "R4 minimum width");

    // R7: target 3
    setup(3, 2, 0, 0, 0);
    pulse(1, 0, 20);
    pulse(1, 0, 5); pulse(1, 0, 5); expect_seen(0, "R7 target 3 early");
    pulse(1, 0, 5); expect_seen(1, "R7 target 3 reached");
    pulse(1, 0, 5); expect_seen(0, "R7 target 3 after");

    // R7: target 0 fires at vsync
    setup(0, 2, 0, 0, 0);
    pulse(1, 0, 20); expect_seen(1, "R7 target 0");
    pulse(1, 0, 5);  expect_seen(0, "R7 target 0 hsync");

    // R8: disabled settings
    setup(0, 0, 0, 0, 0);
    pulse(1, 0, 20); pulse(1, 0, 5); expect_seen(0, "R8 mode 0");
    setup(0, 1, 0, 0, 0);
    pulse(1, 0, 20); pulse(1, 0, 5); expect_seen(0, "R8 mode 1");
    setup(0, 3, 0, 0, 0);
    te_en = 1'b0;
    pulse(1, 0, 20); expect_seen(0, "R8 enable low");
    te_en = 1'b1;

    // R5: both polarities inverted, idle high
    setup(0, 3, 1, 1, 1);
    pulse(0, 1, 20); expect_seen(1, "R5 inverted vsync");
    pulse(0, 1, 6);  expect_seen(0, "R5 inverted hsync in vsync mode");
    setup(1, 2, 1, 1, 1);
    pulse(0, 1, 20); pulse(0, 1, 5); expect_seen(1, "R5 inverted line match");
    setup(0, 0, 0, 0, 0);

    // R2: divide by 4
    div_sel = 3'd3;
    setup(0, 3, 0, 0, 0);
    pulse(1, 0, 40); expect_seen(0, "R2 40 clocks is hsync at div 4");
    setup(1, 2, 0, 0, 0);
    pulse(1, 0, 100); pulse(1, 0, 4); expect_seen(0, "R2 4 clocks ignored at div 4");
    pulse(1, 0, 40);  expect_seen(1, "R2 line match at div 4");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule